// File: doc/BRIEF.md
# Time-Slotted Stereo Serial Audio Transmitter

This block turns one stereo pair of parallel audio samples into a serial bit stream on a data line that several devices may share. The bit clock times every bit, and the word clock marks the two halves of each frame: the low half carries the left sample and the high half carries the right sample. Each half is a fixed number of bit-clock cycles, set by a parameter. The block writes the word either aligned to the start of the half (left-justified) or ending on the last cycle of the half (right-justified). Four word lengths are available.

With time-slot operation enabled, the half-frame holds two slots, and a select input picks the one this device uses. In left-justified format the slots are measured forward from the start of the half. In right-justified format they are measured back from its end. One word length separates the two slots in both cases. Outside its own slot the device lowers an output enable so that the line is free for others. With time-slot operation disabled, the block drives the line on every cycle. Bits that fall outside the half-frame are dropped.

All logic is clocked on the falling edge of the bit clock. A receiver can therefore sample on the rising edge.

Top module: `tdm_tx_serializer`

## Requirements
- R1: While `rst` is high, and afterwards until the first change of the word-clock level has been sampled, `sdata` and `sdata_oe` are both 0.
- R2: `lrclk` is sampled on every falling edge of `bclk`. When an edge E samples a level that differs from the level sampled at the previous edge, a new half-frame begins. The output for half-frame position p (p = 0 .. HALF_BITS-1) is driven from falling edge E+p+1 until the next falling edge. Both outputs change only on falling edges.
- R3: The configuration inputs and the sample are captured only at edge E. The sample is `left_in` when the new level is 0 and `right_in` when it is 1. Changes to `left_in`, `right_in`, `wlen_sel`, `rj_sel`, `tdm_en` or `slot_sel` later in the half-frame have no effect on that half-frame.
- R4: The `wlen_sel` code gives the word length W: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. Bits W-1 down to 0 of the captured sample are sent MSB first, one per position. Sample bits above W-1 are ignored.
- R5: With `tdm_en` = 0, `sdata_oe` is 1 on every cycle once a half-frame has begun, and `slot_sel` has no effect. The window of W positions starts at position 0 when `rj_sel` = 0 and at position HALF_BITS-W when `rj_sel` = 1. Outside the window `sdata` is 0.
- R6: With `tdm_en` = 1 and `rj_sel` = 0 (left-justified), the window starts at position 0 when `slot_sel` = 0 and at position W when `slot_sel` = 1.
- R7: With `tdm_en` = 1 and `rj_sel` = 1 (right-justified), slot 0 ends at position HALF_BITS-1, and slot 1 ends W positions earlier. The window therefore starts at HALF_BITS-W-W·`slot_sel`.
- R8: With `tdm_en` = 1, `sdata_oe` is 1 exactly on the window positions and 0 on every other cycle, and `sdata` is 0 whenever `sdata_oe` is 0.
- R9: Window positions that fall before position 0 or after position HALF_BITS-1 are dropped, together with the bits they would carry. `sdata_oe` is never held across a half-frame boundary by a window.
- R10: If no change of level is sampled after position HALF_BITS-1, every further cycle lies outside any window until the next change. In time-slot mode `sdata_oe` is 0 on those cycles. Otherwise `sdata_oe` is 1 and `sdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| lrclk | input | 1 | Word clock; low half carries left, high half carries right |
| left_in | input | SAMPLE_W | Left sample, right-aligned |
| right_in | input | SAMPLE_W | Right sample, right-aligned |
| wlen_sel | input | 2 | Word length code (16/20/24/32) |
| rj_sel | input | 1 | 0 = left-justified, 1 = right-justified |
| tdm_en | input | 1 | Enable time-slot operation |
| slot_sel | input | 1 | Slot choice in time-slot mode |
| sdata | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Drive enable for the shared data line |

## Verification
The bench builds the block with HALF_BITS = 48 instead of the default 64. With that setting a 24-bit word in slot 1 fills the half exactly, ending on its last position. A 32-bit word in slot 1 runs past the end in left-justified format and starts before position 0 in right-justified format, so both drop paths are exercised. A half-frame stretched beyond 48 cycles shows how the outputs behave once no window remains. The default of 64 would fit every slot, so the truncation logic would never run.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic [1:0] {
    WL16 = 2'd0,
    WL20 = 2'd1,
    WL24 = 2'd2,
    WL32 = 2'd3
  } wlen_e;

  typedef struct packed {
    logic  rj;
    logic  tdm;
    logic  slot;
    wlen_e wlen;
  } tx_cfg_t;

  function automatic int unsigned wlen_bits(wlen_e w);
    case (w)
      WL16:    return 16;
      WL20:    return 20;
      WL24:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker #(
  parameter int HALF_BITS = 64,
  localparam int CNT_W = $clog2(HALF_BITS + 1)
) (
  input  logic             bclk,
  input  logic             rst,
  input  logic             lrclk,
  output logic             half_start,
  output logic [CNT_W-1:0] pos_q,
  output logic             started_q
);

  localparam logic [CNT_W-1:0] IDLE_POS = CNT_W'(HALF_BITS);

  logic lr_q;

  assign half_start = (lrclk != lr_q);

  // position counter; parks at IDLE_POS when the word clock stalls
  always_ff @(negedge bclk) begin
    if (rst) begin
      lr_q      <= lrclk;
      pos_q     <= IDLE_POS;
      started_q <= 1'b0;
    end else begin
      lr_q <= lrclk;
      if (half_start) begin
        pos_q     <= '0;
        started_q <= 1'b1;
      end else if (pos_q < IDLE_POS) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  AST_POS_BOUNDED: assert property (@(negedge bclk) disable iff (rst)
    pos_q <= IDLE_POS); // R9

endmodule

// File: rtl/tdm_sample_capture.sv
module tdm_sample_capture
  import tdm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                bclk,
  input  logic                rst,
  input  logic                capture,
  input  logic                lrclk,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  tx_cfg_t             cfg_in,
  output tx_cfg_t             cfg_q,
  output logic [SAMPLE_W-1:0] word_q
);

  always_ff @(negedge bclk) begin
    if (rst) begin
      cfg_q  <= '0;
      word_q <= '0;
    end else if (capture) begin
      cfg_q  <= cfg_in;
      word_q <= lrclk ? right_in : left_in;
    end
  end

  AST_HOLD_WITHIN_HALF: assert property (@(negedge bclk) disable iff (rst)
    !capture |=> ($stable(cfg_q) && $stable(word_q))); // R3

endmodule

// File: rtl/tdm_slot_window.sv
module tdm_slot_window
  import tdm_tx_pkg::*;
#(
  parameter int HALF_BITS = 64,
  parameter int SAMPLE_W  = 32,
  localparam int CNT_W = $clog2(HALF_BITS + 1),
  localparam int IDX_W = $clog2(SAMPLE_W),
  localparam int SW    = CNT_W + 8
) (
  input  logic [CNT_W-1:0] pos,
  input  tx_cfg_t          cfg,
  output logic             in_win,
  output logic [IDX_W-1:0] bit_idx
);

  localparam logic signed [SW-1:0] HALF_S = SW'(HALF_BITS);
  localparam logic signed [SW-1:0] ONE_S  = SW'(1);

  logic signed [SW-1:0] w_s, off_s, start_s, pos_s, k_s;

  always_comb begin
    w_s     = $signed(SW'(wlen_bits(cfg.wlen)));
    off_s   = (cfg.tdm && cfg.slot) ? w_s : '0;
    // left-justified counts from the half start, right-justified from its end
    start_s = cfg.rj ? (HALF_S - w_s - off_s) : off_s;
    pos_s   = $signed({{(SW-CNT_W){1'b0}}, pos});
    k_s     = pos_s - start_s;
    in_win  = (pos_s < HALF_S) && !k_s[SW-1] && (k_s < w_s);
    bit_idx = IDX_W'(w_s - k_s - ONE_S);
  end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_tx_pkg::*;
#(
  parameter int HALF_BITS = 64,
  parameter int SAMPLE_W  = 32,
  localparam int CNT_W = $clog2(HALF_BITS + 1),
  localparam int IDX_W = $clog2(SAMPLE_W)
) (
  input  logic                bclk,
  input  logic                rst,
  input  logic                lrclk,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic [1:0]          wlen_sel,
  input  logic                rj_sel,
  input  logic                tdm_en,
  input  logic                slot_sel,
  output logic                sdata,
  output logic                sdata_oe
);

  logic             half_start;
  logic [CNT_W-1:0] pos_q;
  logic             started_q;
  tx_cfg_t          cfg_in, cfg_q;
  logic [SAMPLE_W-1:0] word_q;
  logic             in_win;
  logic [IDX_W-1:0] bit_idx;

  always_comb begin
    cfg_in.rj   = rj_sel;
    cfg_in.tdm  = tdm_en;
    cfg_in.slot = slot_sel;
    cfg_in.wlen = wlen_e'(wlen_sel);
  end

  tdm_frame_tracker #(.HALF_BITS(HALF_BITS)) u_track (
    .bclk      (bclk),
    .rst       (rst),
    .lrclk     (lrclk),
    .half_start(half_start),
    .pos_q     (pos_q),
    .started_q (started_q)
  );

  tdm_sample_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .bclk    (bclk),
    .rst     (rst),
    .capture (half_start),
    .lrclk   (lrclk),
    .left_in (left_in),
    .right_in(right_in),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q),
    .word_q  (word_q)
  );

  tdm_slot_window #(.HALF_BITS(HALF_BITS), .SAMPLE_W(SAMPLE_W)) u_win (
    .pos    (pos_q),
    .cfg    (cfg_q),
    .in_win (in_win),
    .bit_idx(bit_idx)
  );

  // registered line outputs, updated on the falling edge
  always_ff @(negedge bclk) begin
    if (rst) begin
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
    end else begin
      sdata    <= in_win & word_q[bit_idx];
      sdata_oe <= started_q & (cfg_q.tdm ? in_win : 1'b1);
    end
  end

  AST_QUIET_WHEN_RELEASED: assert property (@(negedge bclk) disable iff (rst)
    !sdata_oe |-> !sdata); // R8

  AST_PLAIN_MODE_DRIVES: assert property (@(negedge bclk) disable iff (rst)
    ($past(started_q) && !$past(cfg_q.tdm)) |-> sdata_oe); // R5

  AST_OE_INSIDE_HALF: assert property (@(negedge bclk) disable iff (rst)
    (sdata_oe && $past(cfg_q.tdm)) |-> ($past(pos_q) < CNT_W'(HALF_BITS))); // R9

endmodule

// File: tb/sim_tdm_tx_serializer.sv
module sim_tdm_tx_serializer;

  localparam int HALF = 48;
  localparam int NV   = 10;

  logic bclk = 1'b1;
  logic rst = 1'b1;
  logic lrclk = 1'b1;
  logic [31:0] left_in = '0, right_in = '0;
  logic [1:0] wlen_sel = '0;
  logic rj_sel = 1'b0, tdm_en = 1'b0, slot_sel = 1'b0;
  logic sdata, sdata_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [1:0] pipe0 = 2'b00, pipe1 = 2'b00;
  string tag0 = "R1", tag1 = "R1";

  always #4 bclk = ~bclk;

  tdm_tx_serializer #(.HALF_BITS(HALF), .SAMPLE_W(32)) u0 (
    .bclk(bclk), .rst(rst), .lrclk(lrclk),
    .left_in(left_in), .right_in(right_in),
    .wlen_sel(wlen_sel), .rj_sel(rj_sel), .tdm_en(tdm_en), .slot_sel(slot_sel),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );

  // fields: {rj, tdm, slot, wlen[1:0], left[31:0], right[31:0]}
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 2'd0, 32'h0000_A5C3, 32'h0000_3C5A},
    {1'b0, 1'b1, 1'b1, 2'd0, 32'h0000_8001, 32'h0000_7FFE},
    {1'b0, 1'b1, 1'b1, 2'd2, 32'h00C0_FFEE, 32'h0012_3456},
    {1'b0, 1'b1, 1'b1, 2'd3, 32'hDEAD_BEEF, 32'h1357_9BDF},
    {1'b1, 1'b1, 1'b0, 2'd2, 32'h00AB_CDEF, 32'h0055_AA55},
    {1'b1, 1'b1, 1'b1, 2'd0, 32'hFFFF_9669, 32'h1234_C33C},
    {1'b1, 1'b1, 1'b1, 2'd3, 32'hF0E1_D2C3, 32'h8765_4321},
    {1'b0, 1'b0, 1'b1, 2'd1, 32'hFFF5_A5A5, 32'h000C_3C3C},
    {1'b1, 1'b0, 1'b0, 2'd3, 32'h8000_0001, 32'h7FFF_FFFE},
    {1'b0, 1'b1, 1'b0, 2'd1, 32'h000F_0F0F, 32'h0009_9999}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2/R4/R6/R8";
      1: return "R2/R6";
      2: return "R2/R6/R9";
      3: return "R2/R9";
      4: return "R2/R7";
      5: return "R2/R4/R7";
      6: return "R2/R9";
      7: return "R2/R4/R5";
      8: return "R2/R5";
      default: return "R2/R8";
    endcase
  endfunction

  // expected {oe, data} for half-frame position pos
  function automatic logic [1:0] model(int pos, logic rj, logic tdm, logic slot,
                                       logic [1:0] wl, logic [31:0] word);
    int w, off, st, k;
    logic act, sd, oe;
    w   = (wl == 2'd3) ? 32 : 16 + 4 * int'(wl);
    off = (tdm && slot) ? w : 0;
    st  = rj ? HALF - w - off : off;
    k   = pos - st;
    act = (pos < HALF) && (k >= 0) && (k < w);
    sd  = act ? word[w-1-k] : 1'b0;
    oe  = tdm ? act : 1'b1;
    return {oe, sd};
  endfunction

  task automatic tick(input logic [1:0] e, input string tag);
    @(posedge bclk);
    checks++;
    if ({sdata_oe, sdata} !== pipe1) begin
      failures++;
      $display("FAIL %s: {oe,data} actual=%b expected=%b at %0t",
               tag1, {sdata_oe, sdata}, pipe1, $time);
    end
    pipe1 = pipe0;
    tag1  = tag0;
    pipe0 = e;
    tag0  = tag;
  endtask

  task automatic run_half(input logic level, input logic [68:0] v, input int len,
                          input string tag, input bit perturb);
    logic rj, tdm, slot;
    logic [1:0] wl;
    logic [31:0] lw, rw, word;
    rj = v[68]; tdm = v[67]; slot = v[66]; wl = v[65:64];
    lw = v[63:32]; rw = v[31:0];
    word = level ? rw : lw;
    for (int k = 0; k < len; k++) begin
      tick(model(k, rj, tdm, slot, wl, word), tag);
      if (k == 0) begin
        lrclk = level; left_in = lw; right_in = rw;
        rj_sel = rj; tdm_en = tdm; slot_sel = slot; wlen_sel = wl;
      end
      if (perturb && k == 3) begin
        left_in = ~lw; right_in = ~rw; slot_sel = ~slot;
        wlen_sel = wl ^ 2'b01; rj_sel = ~rj; tdm_en = ~tdm;
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state, then idle until the first level change
    for (int i = 0; i < 4; i++) tick(2'b00, "R1");
    rst = 1'b0;
    for (int i = 0; i < 2; i++) tick(2'b00, "R1");

    for (int i = 0; i < NV; i++) begin
      run_half(1'b0, VEC[i], HALF, vec_tag(i), 1'b0);
      run_half(1'b1, VEC[i], HALF, vec_tag(i), 1'b0);
    end

    // R3: inputs changed mid-half are ignored
    run_half(1'b0, VEC[0], HALF, "R3", 1'b1);
    run_half(1'b1, VEC[4], HALF, "R3", 1'b1);

    // R10: word clock stalls after a window ending on the last position
    run_half(1'b0, VEC[2], HALF + 6, "R10", 1'b0);
    run_half(1'b1, VEC[7], HALF + 4, "R10", 1'b0);
    tick(2'b10, "R10");
    tick(2'b10, "R10");
    finish_run();
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL R2: watchdog expired actual=hung expected=done");
    finish_run();
  end

endmodule